// File: doc/BRIEF.md
# Error-Correcting Register File with Fault Injection

This block is a bank of 32 registers, 32 bits wide. Every register carries seven check bits: six Hamming parity bits and one overall parity bit. Together they let a read repair any single flipped bit and detect any two flipped bits. A command port selects a register and an operation in a single 7-bit word, with a separate 32-bit data word for writes. The read data and a 2-bit error status appear on registered outputs one clock edge after the command.

A small memory-mapped slave port gives a test host three words. The first is a fault-injection word. Writing it overwrites the data bits of the register that the command port wrote most recently, and leaves that register's check bits untouched. This lets the host plant deliberate errors. The other two words are a count of completed reads and a count of reads that needed a repair.

When a read repairs a single-bit error, the repaired word and fresh check bits go back into the register in the same cycle (scrubbing). A double error is reported and left in place. As an example of the coding, the data word 0x1 stores the check bits 1000011 (overall parity first, then parity bits 32, 16, 8, 4, 2, 1).

Top module: `ecc_regfile`

## Requirements
- R1: The command word `cmd_i` carries the register index in bits [6:2] and the operation in bits [1:0]. Operation 2'b10 stores `wdata_i` into the indexed register.
- R2: Operation 2'b01 reads the indexed register. After the next rising edge, `rdata_o` holds the data and `result_o` holds the status. A register with no error returns its stored word with status 2'b00.
- R3: A read of a register whose data differs from the last word written to it in exactly one bit returns the written word with status 2'b01.
- R4: A read that repairs an error writes the repaired word back, so a second read of the same register returns status 2'b00.
- R5: A read of a register whose data differs from its written word in exactly two bits returns status 2'b10 with the stored data unchanged. It writes nothing back, so a repeat read reports 2'b10 again.
- R6: Operations 2'b00 and 2'b11 change neither `rdata_o`, `result_o` nor any register.
- R7: After the bus master raises `bus_valid_i`, `bus_ready_o` goes high for exactly one cycle, one cycle later. `bus_rdata_o` is valid in that cycle.
- R8: A bus write at byte offset 0x0 replaces the data bits of the register most recently written by the command port, or of register 0 if there has been no such write since reset. The check bits are left as they were. A bus read at offset 0x0 returns those data bits without repair.
- R9: Offset 0x4 reads the number of read operations and offset 0x8 reads the number of reads that returned status 2'b01. Bus writes to these offsets have no effect.
- R10: After reset, all registers hold 0 with valid check bits, both counters read 0, `rdata_o` is 0 and `result_o` is 2'b00.
- R11: `result_o` never shows 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 7 | Index [6:2], operation [1:0] |
| wdata_i | input | 32 | Word to store on a write operation |
| rdata_o | output | 32 | Data from the last read |
| result_o | output | 2 | Status of the last read: 00 clean, 01 repaired, 10 uncorrectable |
| bus_valid_i | input | 1 | Bus request valid |
| bus_we_i | input | 1 | Bus request is a write |
| bus_addr_i | input | 4 | Bus byte offset |
| bus_wdata_i | input | 32 | Bus write data |
| bus_ready_o | output | 1 | Bus acknowledge, one cycle |
| bus_rdata_o | output | 32 | Bus read data, valid with `bus_ready_o` |

## Verification
The hard part to reach from the ports is a register that holds an error. The check bits can only be wrong relative to the data through the injection word. That word only reaches the most recently written register, so the stimulus has to write a register first and then inject into it. The bench keeps two copies of each register: the word last written, and the data bits actually stored. The number of bits in which they differ predicts the status, the returned data and whether a scrub happens. Random stimulus mixes writes, reads and injections of zero, one or two flipped bits. Directed cases cover a repeat read after a scrub, a persistent double error and ignored writes to the counter offsets.

// File: rtl/ecc_regfile_pkg.sv
package ecc_regfile_pkg;

  localparam int DATA_W = 32;
  localparam int PAR_W  = 6;
  localparam int CHK_W  = PAR_W + 1;
  localparam int CODE_N = DATA_W + PAR_W;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RES_CLEAN = 2'd0,
    RES_FIXED = 2'd1,
    RES_FATAL = 2'd2,
    RES_SPARE = 2'd3
  } res_e;

  // Hamming position of data bit bit_idx: positions run 1..CODE_N, skipping powers of two
  function automatic logic [PAR_W-1:0] slot_of(input int bit_idx);
    logic [PAR_W-1:0] slot;
    int seen;
    slot = '0;
    seen = 0;
    for (int p = 1; p <= CODE_N; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (seen == bit_idx) slot = PAR_W'(p);
        seen++;
      end
    end
    return slot;
  endfunction

  // XOR of the positions of all set data bits
  function automatic logic [PAR_W-1:0] parity_of(input logic [DATA_W-1:0] d);
    logic [PAR_W-1:0] s;
    s = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (d[i]) s = s ^ slot_of(i);
    end
    return s;
  endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_regfile_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);

  logic [PAR_W-1:0] par;

  always_comb begin
    par   = parity_of(data_i);
    chk_o = {(^data_i) ^ (^par), par};
  end

endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_regfile_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output res_e              res_o
);

  logic [PAR_W-1:0] syn;
  logic             odd;

  always_comb begin
    syn    = parity_of(data_i) ^ chk_i[PAR_W-1:0];
    odd    = ^{data_i, chk_i};
    data_o = data_i;
    res_o  = RES_CLEAN;
    if (odd) begin
      // odd overall parity: one bit flipped; syndrome points at it
      if (int'(syn) > CODE_N) begin
        res_o = RES_FATAL;
      end else begin
        res_o = RES_FIXED;
        for (int i = 0; i < DATA_W; i++) begin
          if (slot_of(i) == syn) data_o[i] = ~data_i[i];
        end
      end
    end else if (syn != '0) begin
      // even parity with nonzero syndrome: two bits flipped
      res_o = RES_FATAL;
    end
  end

endmodule

// File: rtl/ecc_bus_port.sv
module ecc_bus_port
  import ecc_regfile_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              inj_we_o,
  output logic [DATA_W-1:0] inj_data_o,
  input  logic [DATA_W-1:0] inj_peek_i,
  input  logic              rd_evt_i,
  input  logic              fix_evt_i,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic [CNT_W-1:0]  fix_cnt_o
);

  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_INJ = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_RDC = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_FXC = WORD_W'(2);

  logic              ready_q, ready_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [CNT_W-1:0]  rdc_q, rdc_d, fxc_q, fxc_d;
  logic              take, aligned;
  logic [WORD_W-1:0] word;

  always_comb begin
    take    = valid_i & ~ready_q;
    aligned = (addr_i[1:0] == 2'b00);
    word    = addr_i[ADDR_W-1:2];
    ready_d = take;
    rdata_d = rdata_q;
    if (take && !we_i) begin
      rdata_d = '0;
      if (aligned) begin
        unique case (word)
          W_INJ:   rdata_d = inj_peek_i;
          W_RDC:   rdata_d = DATA_W'(rdc_q);
          W_FXC:   rdata_d = DATA_W'(fxc_q);
          default: rdata_d = '0;
        endcase
      end
    end
    rdc_d = rdc_q + CNT_W'(rd_evt_i);
    fxc_d = fxc_q + CNT_W'(fix_evt_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      rdata_q <= '0;
      rdc_q   <= '0;
      fxc_q   <= '0;
    end else begin
      ready_q <= ready_d;
      if (take) rdata_q <= rdata_d;
      if (rd_evt_i) rdc_q <= rdc_d;
      if (fix_evt_i) fxc_q <= fxc_d;
    end
  end

  assign inj_we_o   = take & we_i & aligned & (word == W_INJ);
  assign inj_data_o = wdata_i;
  assign ready_o    = ready_q;
  assign rdata_o    = rdata_q;
  assign rd_cnt_o   = rdc_q;
  assign fix_cnt_o  = fxc_q;

endmodule

// File: rtl/ecc_regfile.sv
module ecc_regfile
  import ecc_regfile_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(DEPTH)+1:0]    cmd_i,
  input  logic [31:0]                 wdata_i,
  output logic [31:0]                 rdata_o,
  output logic [1:0]                  result_o,
  input  logic                        bus_valid_i,
  input  logic                        bus_we_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [31:0]                 bus_wdata_i,
  output logic                        bus_ready_o,
  output logic [31:0]                 bus_rdata_o
);

  localparam int IDX_W = $clog2(DEPTH);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic [IDX_W-1:0]  idx;
  op_e               op;
  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [CHK_W-1:0]  mem_c [DEPTH];
  logic [DATA_W-1:0] nxt_d [DEPTH];
  logic [CHK_W-1:0]  nxt_c [DEPTH];
  logic [DEPTH-1:0]  ent_en;

  logic [DATA_W-1:0] fix_d;
  res_e              dec_res;
  logic [CHK_W-1:0]  wr_chk, sc_chk;
  logic              inj_we;
  logic [DATA_W-1:0] inj_data;
  logic [IDX_W-1:0]  tgt_q, tgt_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [1:0]        res_q, res_d;
  logic              rd_evt, fix_evt;
  logic [CNT_W-1:0]  read_cnt, fix_cnt;

  assign idx = cmd_i[IDX_W+1:2];
  assign op  = op_e'(cmd_i[1:0]);

  ecc_decoder u_dec (
    .data_i (mem_d[idx]),
    .chk_i  (mem_c[idx]),
    .data_o (fix_d),
    .res_o  (dec_res)
  );

  ecc_encoder u_enc_wr (.data_i(wdata_i), .chk_o(wr_chk));
  ecc_encoder u_enc_sc (.data_i(fix_d),   .chk_o(sc_chk));

  assign rd_evt  = (op == OP_READ);
  assign fix_evt = rd_evt && (dec_res == RES_FIXED);

  ecc_bus_port #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bus (
    .clk        (clk),
    .rst_n      (rst_s),
    .valid_i    (bus_valid_i),
    .we_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .ready_o    (bus_ready_o),
    .rdata_o    (bus_rdata_o),
    .inj_we_o   (inj_we),
    .inj_data_o (inj_data),
    .inj_peek_i (mem_d[tgt_q]),
    .rd_evt_i   (rd_evt),
    .fix_evt_i  (fix_evt),
    .rd_cnt_o   (read_cnt),
    .fix_cnt_o  (fix_cnt)
  );

  // next state: command write > injection > scrub
  always_comb begin
    tgt_d   = (op == OP_WRITE) ? idx : tgt_q;
    rdata_d = rdata_q;
    res_d   = res_q;
    if (rd_evt) begin
      rdata_d = fix_d;
      res_d   = dec_res;
    end
    for (int g = 0; g < DEPTH; g++) begin
      nxt_d[g]  = mem_d[g];
      nxt_c[g]  = mem_c[g];
      ent_en[g] = 1'b0;
      if (op == OP_WRITE && idx == IDX_W'(g)) begin
        nxt_d[g]  = wdata_i;
        nxt_c[g]  = wr_chk;
        ent_en[g] = 1'b1;
      end else if (inj_we && tgt_q == IDX_W'(g)) begin
        nxt_d[g]  = inj_data;
        ent_en[g] = 1'b1;
      end else if (fix_evt && idx == IDX_W'(g)) begin
        nxt_d[g]  = fix_d;
        nxt_c[g]  = sc_chk;
        ent_en[g] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      tgt_q   <= '0;
      rdata_q <= '0;
      res_q   <= RES_CLEAN;
      for (int g = 0; g < DEPTH; g++) begin
        mem_d[g] <= '0;
        mem_c[g] <= '0;
      end
    end else begin
      if (op == OP_WRITE) tgt_q <= tgt_d;
      if (rd_evt) begin
        rdata_q <= rdata_d;
        res_q   <= res_d;
      end
      for (int g = 0; g < DEPTH; g++) begin
        if (ent_en[g]) begin
          mem_d[g] <= nxt_d[g];
          mem_c[g] <= nxt_c[g];
        end
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign result_o = res_q;

endmodule

// File: rtl/ecc_regfile_chk.sv
module ecc_regfile_chk #(
  parameter int CMD_W = 7,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CMD_W-1:0] cmd_i,
  input logic [31:0]      rdata_o,
  input logic [1:0]       result_o,
  input logic             bus_valid_i,
  input logic             bus_ready_o,
  input logic [CNT_W-1:0] rd_cnt,
  input logic [CNT_W-1:0] fix_cnt
);

  assert_ready_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && !bus_ready_o) |=> bus_ready_o);

  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready_o |=> !bus_ready_o);

  assert_no_spare_R11: assert property (@(posedge clk) disable iff (!rst_n)
    result_o != 2'b11);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i[1:0] == 2'b00 || cmd_i[1:0] == 2'b11) |=> ($stable(rdata_o) && $stable(result_o)));

  assert_read_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i[1:0] == 2'b01) |=> (rd_cnt == $past(rd_cnt) + CNT_W'(1)));

  assert_read_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i[1:0] != 2'b01) |=> $stable(rd_cnt));

  assert_fix_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i[1:0] == 2'b01) |=> (fix_cnt == $past(fix_cnt) + CNT_W'(result_o == 2'b01)));

endmodule

bind ecc_regfile ecc_regfile_chk #(.CMD_W($clog2(DEPTH) + 2), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_s),
  .cmd_i       (cmd_i),
  .rdata_o     (rdata_o),
  .result_o    (result_o),
  .bus_valid_i (bus_valid_i),
  .bus_ready_o (bus_ready_o),
  .rd_cnt      (read_cnt),
  .fix_cnt     (fix_cnt)
);

// File: tb/ecc_regfile_bench.sv
module ecc_regfile_bench;

  logic        clk;
  logic        rst_n;
  logic [6:0]  cmd_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic [1:0]  result_o;
  logic        bus_valid_i;
  logic        bus_we_i;
  logic [3:0]  bus_addr_i;
  logic [31:0] bus_wdata_i;
  logic        bus_ready_o;
  logic [31:0] bus_rdata_o;

  ecc_regfile u_ecc_regfile (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .result_o    (result_o),
    .bus_valid_i (bus_valid_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_ready_o (bus_ready_o),
    .bus_rdata_o (bus_rdata_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] gold [32];
  logic [31:0] raw  [32];
  int tgt = 0;
  int exp_rd = 0;
  int exp_fix = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input int idx, input logic [31:0] data);
    @(negedge clk);
    cmd_i   = {idx[4:0], op};
    wdata_i = data;
    @(negedge clk);
    cmd_i   = 7'd0;
  endtask

  task automatic do_write(input int idx, input logic [31:0] data);
    issue(2'b10, idx, data);
    gold[idx] = data;
    raw[idx]  = data;
    tgt       = idx;
  endtask

  task automatic do_read(input int idx, input string req);
    int diff;
    logic [31:0] ed;
    logic [1:0]  er;
    issue(2'b01, idx, 32'h0);
    diff = $countones(raw[idx] ^ gold[idx]);
    exp_rd++;
    if (diff == 0) begin
      ed = gold[idx]; er = 2'b00;
    end else if (diff == 1) begin
      ed = gold[idx]; er = 2'b01;
      raw[idx] = gold[idx];
      exp_fix++;
    end else begin
      ed = raw[idx]; er = 2'b10;
    end
    check({req, " data"}, rdata_o, ed);
    check({req, " status"}, {30'd0, result_o}, {30'd0, er});
  endtask

  task automatic bus_xfer(input logic we, input logic [3:0] addr, input logic [31:0] data,
                          output logic [31:0] rd, output int waited);
    @(negedge clk);
    bus_valid_i = 1'b1;
    bus_we_i    = we;
    bus_addr_i  = addr;
    bus_wdata_i = data;
    waited      = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!bus_ready_o && waited < 10);
    rd          = bus_rdata_o;
    bus_valid_i = 1'b0;
    bus_we_i    = 1'b0;
  endtask

  task automatic inject(input logic [31:0] val);
    logic [31:0] rd;
    int w;
    bus_xfer(1'b1, 4'h0, val, rd, w);
    raw[tgt] = val;
  endtask

  function automatic logic [31:0] flip(input logic [31:0] v, input int k);
    logic [31:0] r;
    int b1, b2;
    r  = v;
    b1 = int'($urandom % 32);
    b2 = (b1 + 1 + int'($urandom % 31)) % 32;
    if (k >= 1) r[b1] = ~r[b1];
    if (k >= 2) r[b2] = ~r[b2];
    return r;
  endfunction

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic [31:0] keep_d;
    logic [1:0]  keep_r;
    int w;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 32; i++) begin
      gold[i] = 32'h0;
      raw[i]  = 32'h0;
    end
    cmd_i = 7'd0; wdata_i = 32'h0;
    bus_valid_i = 1'b0; bus_we_i = 1'b0; bus_addr_i = 4'h0; bus_wdata_i = 32'h0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    check("R10 rdata", rdata_o, 32'h0);
    check("R10 status", {30'd0, result_o}, 32'h0);
    bus_xfer(1'b0, 4'h4, 32'h0, rd, w);
    check("R10 read count", rd, 32'h0);
    check("R7 ready latency", w, 1);
    bus_xfer(1'b0, 4'h8, 32'h0, rd, w);
    check("R10 fix count", rd, 32'h0);
    do_read(7, "R10 entry");

    // R1 R3 R8: directed injection into register 31
    do_write(31, 32'h1);
    do_write(0, 32'h2);
    do_write(1, 32'h3);
    // target is register 1 now; rewrite 31 to retarget
    do_write(31, 32'h1);
    inject(32'h3);
    bus_xfer(1'b0, 4'h0, 32'h0, rd, w);
    check("R8 raw readback", rd, 32'h3);
    do_read(31, "R3 single fix");
    do_read(1, "R1 clean");
    do_read(31, "R4 after scrub");
    bus_xfer(1'b0, 4'h0, 32'h0, rd, w);
    check("R4 scrubbed data", rd, 32'h1);

    // R9: writes to counters ignored
    bus_xfer(1'b1, 4'h4, 32'hFFFF, rd, w);
    bus_xfer(1'b1, 4'h8, 32'hFFFF, rd, w);
    bus_xfer(1'b0, 4'h4, 32'h0, rd, w);
    check("R9 read count", rd, exp_rd);
    bus_xfer(1'b0, 4'h8, 32'h0, rd, w);
    check("R9 fix count", rd, exp_fix);

    // R5: double error persists
    do_write(5, 32'hA5A5_0000);
    inject(32'hA5A5_0003);
    do_read(5, "R5 double");
    do_read(5, "R5 repeat");

    // R6: idle and reserved opcodes
    keep_d = rdata_o;
    keep_r = result_o;
    issue(2'b00, 5, 32'h1234);
    issue(2'b11, 5, 32'h5678);
    check("R6 data hold", rdata_o, keep_d);
    check("R6 status hold", {30'd0, result_o}, {30'd0, keep_r});
    do_read(5, "R6 entry untouched");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int sel;
      int ix;
      sel = int'($urandom % 4);
      ix  = int'($urandom % 32);
      if (sel == 0) do_write(ix, $urandom);
      else if (sel == 3) inject(flip(gold[tgt], int'($urandom % 3)));
      else do_read(ix, "R2 random read");
    end

    bus_xfer(1'b0, 4'h4, 32'h0, rd, w);
    check("R9 final read count", rd, exp_rd);
    bus_xfer(1'b0, 4'h8, 32'h0, rd, w);
    check("R9 final fix count", rd, exp_fix);
    check("R7 final latency", w, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule